// File: doc/BRIEF.md
# DMA channel status and interrupt aggregator

This block keeps one 32-bit control/status word for each channel of a DMA engine and combines the events of all channels into a single level-sensitive interrupt. Software writes a channel's word through a simple write port. The written value acts in three ways at once. Some event flags are cleared by writing a one. A group of control bits is loaded directly from the written value. Two strobe bits set or clear a compare flag. A write also starts the channel or flags it as stopped.

The channel engine reports bus-error, start, end and stop events as one-cycle pulses. The request mapper supplies each channel's live request level. A rising request edge marks a request-asserted event. A falling edge marks an end-of-receive event. The block drives each channel's run and stop bits back to the engine. It also presents a per-channel pending summary and the combined interrupt line.

Software reads one channel's word at a time through a combinational read port. The live request level appears in the returned word but is not stored.

Top module: `dma_stat_irq`

## Requirements
- R1: After reset every channel's status word reads 0x00000008 (only the stop flag, bit 3, set), run_o is all zero, stop_o is all one, and int_summary and irq are zero.
- R2: A write clears each of bits 0 (bus error), 1 (start), 2 (end) and 9 (end-of-receive) for which the written bit is 1. A 0 in those positions leaves the flag unchanged. Writing 1 to bit 4 or bit 10 does not change those flags.
- R3: A write loads bits 31:26 and bit 23 from the written data. Bit 22 (mask-run) and every bit outside the event and control fields always read 0.
- R4: Writing 1 to bit 24 clears the compare flag (bit 10) and writing 1 to bit 25 sets it. When both are written as 1, the flag ends up set.
- R5: A write with bit 31 (run) = 1 clears the stop flag. A write with bit 31 = 0 and bit 22 = 0 sets the stop flag. A write with bit 31 = 0 and bit 22 = 1 leaves the stop flag unchanged.
- R6: Engine pulses set bit 0 (bus error), bit 1 (start), bit 2 (end) and bit 3 (stop) of their channel at the next clock edge. When a pulse and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R7: A rising edge of a channel's request level sets bit 4. A falling edge clears bit 4 and sets bit 9. Bit 8 of the read data shows the current request level and is never stored.
- R8: A channel is pending when start or end is set, or when stop (bit 3) is set with bit 29, end-of-receive (bit 9) with bit 28, or request-asserted (bit 4) with bit 23. Bus error never makes a channel pending. int_summary bit i is channel i's pending state and irq is the OR of all channels, both one cycle after the status word changes.
- R9: run_o[i] mirrors bit 31 and stop_o[i] mirrors bit 3 of channel i's stored status, changing in the same cycle as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one status word |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_data | input | 32 | Write value |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_data | output | 32 | Status word of rd_ch with the live request bit |
| evt_buserr | input | NUM_CH | Bus-error pulse per channel |
| evt_start | input | NUM_CH | Start pulse per channel |
| evt_end | input | NUM_CH | End pulse per channel |
| evt_stop | input | NUM_CH | Stop pulse per channel |
| req_level | input | NUM_CH | Live request level per channel |
| run_o | output | NUM_CH | Run control bit per channel |
| stop_o | output | NUM_CH | Stop flag per channel |
| int_summary | output | NUM_CH | Registered pending bit per channel |
| irq | output | 1 | Combined interrupt level |

## Verification
The hardest case to reach from the ports is a collision in one cycle: a hardware set and a software write-one-to-clear hit the same flag. A request edge arriving while a write updates the same word is a related case. Random traffic seldom lines these up, so directed steps create them on purpose. They drive an end pulse together with a write that clears bit 2, and they write ones to bits 4 and 10 while a request is held high. A long random phase then drives sparse pulses, request toggles and mixed writes on all channels together. A bench model predicts every status word, the summary and irq one cycle later.

// File: rtl/dma_stat_pkg.sv
// Package: bit positions, field masks and the pending rule shared by the
// status aggregator. Assumes a 32-bit status word per channel.
package dma_stat_pkg;

    localparam int STAT_W = 32;

    localparam int B_BUSERR  = 0;
    localparam int B_START   = 1;
    localparam int B_DONE    = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASIE   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EORSTOP = 26;
    localparam int B_EORJMP  = 27;
    localparam int B_EORIE   = 28;
    localparam int B_STOPIE  = 29;
    localparam int B_NODESC  = 30;
    localparam int B_RUN     = 31;

    // Event bits kept across a write (bit 8 is never stored)
    localparam logic [STAT_W-1:0] KEEP_MASK = 32'h0000_061F;
    // Control bits loaded straight from the written value
    localparam logic [STAT_W-1:0] LOAD_MASK = 32'hFC80_0000;
    // Event bits cleared by writing a one
    localparam logic [STAT_W-1:0] W1C_MASK  = 32'h0000_0207;
    // Reset value: stop flag only
    localparam logic [STAT_W-1:0] RST_VAL   = 32'h0000_0008;

    typedef struct packed {
        logic buserr;
        logic start;
        logic done;
        logic stop;
    } eng_evt_t;

    // Pending rule: gated stop/eor/ras, ungated start/done, bus error excluded
    function automatic logic chan_pending(logic [STAT_W-1:0] s);
        return s[B_START] | s[B_DONE]
             | (s[B_STOP] & s[B_STOPIE])
             | (s[B_EOR]  & s[B_EORIE])
             | (s[B_RAS]  & s[B_RASIE]);
    endfunction

endpackage

// File: rtl/dma_chan_csr.sv
// Module: one channel's status word. Merges a software write with same-cycle
// hardware events, hardware sets taking priority. Assumes evt pulses are one
// cycle wide and req_in is synchronous to clk.
module dma_chan_csr
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wr_data,
    input  eng_evt_t          evt,
    input  logic              req_in,
    output logic [STAT_W-1:0] csr_o,
    output logic              pend_o
);

    logic [STAT_W-1:0] csr_q;
    logic [STAT_W-1:0] sw_val;
    logic [STAT_W-1:0] nxt_val;
    logic              req_q;
    logic              req_rise;
    logic              req_fall;

    assign req_rise = req_in & ~req_q;
    assign req_fall = ~req_in & req_q;

    // Software write effect on the stored word
    always_comb begin
        sw_val = csr_q;
        if (wr_hit) begin
            sw_val = (csr_q & KEEP_MASK & ~(wr_data & W1C_MASK))
                   | (wr_data & LOAD_MASK);
            if (wr_data[B_RUN])
                sw_val[B_STOP] = 1'b0;
            else if (!wr_data[B_MASKRUN])
                sw_val[B_STOP] = 1'b1;
            if (wr_data[B_CMPCLR])
                sw_val[B_CMP] = 1'b0;
            if (wr_data[B_CMPSET])
                sw_val[B_CMP] = 1'b1;
        end
    end

    // Hardware events applied on top of the software result
    always_comb begin
        nxt_val = sw_val;
        nxt_val[B_BUSERR] = sw_val[B_BUSERR] | evt.buserr;
        nxt_val[B_START]  = sw_val[B_START]  | evt.start;
        nxt_val[B_DONE]   = sw_val[B_DONE]   | evt.done;
        nxt_val[B_STOP]   = sw_val[B_STOP]   | evt.stop;
        if (req_rise)
            nxt_val[B_RAS] = 1'b1;
        if (req_fall) begin
            nxt_val[B_RAS] = 1'b0;
            nxt_val[B_EOR] = 1'b1;
        end
    end

    // Status register and request history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= RST_VAL;
            req_q <= 1'b0;
        end else begin
            csr_q <= nxt_val;
            req_q <= req_in;
        end
    end

    assign csr_o  = csr_q;
    assign pend_o = chan_pending(csr_q);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> csr_q == RST_VAL);
    a_r6_hw_end_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt.done |=> csr_q[B_DONE]);
    a_r2_w1c_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[B_DONE] && !evt.done) |=> !csr_q[B_DONE]);
    a_r4_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[B_CMPSET]) |=> csr_q[B_CMP]);
    a_r5_stop_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_data[B_RUN] && !wr_data[B_MASKRUN]) |=> csr_q[B_STOP]);
    a_r3_run_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> csr_q[B_RUN] == $past(wr_data[B_RUN]));
    a_r3_maskrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_q[B_MASKRUN] && !csr_q[B_REQ]);
    a_r7_fall_sets_eor: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_in && req_q) |=> (csr_q[B_EOR] && !csr_q[B_RAS]));

endmodule

// File: rtl/dma_irq_merge.sv
// Module: registers each channel's pending bit into the summary vector and
// ORs it into one interrupt level. Assumes pend_i is from registered state.
module dma_irq_merge #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend_i,
    output logic [NUM_CH-1:0] summary_o,
    output logic              irq_o
);

    // Summary and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_o <= '0;
            irq_o     <= 1'b0;
        end else begin
            summary_o <= pend_i;
            irq_o     <= |pend_i;
        end
    end

    a_r8_irq_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (summary_o != '0));

endmodule

// File: rtl/dma_csr_rdmux.sv
// Module: selects one channel's stored word for readback and inserts the live
// request level at bit 8. Out-of-range channels read as zero.
module dma_csr_rdmux
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0][STAT_W-1:0] csr_all,
    input  logic [NUM_CH-1:0]             req_level,
    input  logic [CH_W-1:0]               rd_ch,
    output logic [STAT_W-1:0]             rd_data
);

    // Read selection with live request-pending bit
    always_comb begin
        rd_data = '0;
        if (int'(rd_ch) < NUM_CH) begin
            rd_data        = csr_all[rd_ch];
            rd_data[B_REQ] = req_level[rd_ch];
        end
    end

endmodule

// File: rtl/dma_stat_irq.sv
// Module: top of the status/interrupt aggregator. Replicates one status word
// per channel, exposes run/stop bits, the pending summary and one interrupt.
// Assumes a single write per cycle and event inputs synchronous to clk.
module dma_stat_irq
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [31:0]       wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] evt_buserr,
    input  logic [NUM_CH-1:0] evt_start,
    input  logic [NUM_CH-1:0] evt_end,
    input  logic [NUM_CH-1:0] evt_stop,
    input  logic [NUM_CH-1:0] req_level,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] stop_o,
    output logic [NUM_CH-1:0] int_summary,
    output logic              irq
);

    logic [NUM_CH-1:0][STAT_W-1:0] csr_all;
    logic [NUM_CH-1:0]             pend;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        eng_evt_t ev;
        logic     hit;

        assign ev.buserr = evt_buserr[i];
        assign ev.start  = evt_start[i];
        assign ev.done   = evt_end[i];
        assign ev.stop   = evt_stop[i];
        assign hit       = wr_en && (wr_ch == CH_W'(i));

        dma_chan_csr u_csr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .wr_data (wr_data),
            .evt     (ev),
            .req_in  (req_level[i]),
            .csr_o   (csr_all[i]),
            .pend_o  (pend[i])
        );

        assign run_o[i]  = csr_all[i][B_RUN];
        assign stop_o[i] = csr_all[i][B_STOP];

        a_r8_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
            csr_all[i][B_DONE] |=> irq && int_summary[i]);
        a_r8_buserr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!csr_all[i][B_START] && !csr_all[i][B_DONE] && !csr_all[i][B_STOP]
             && !csr_all[i][B_EOR] && !csr_all[i][B_RAS]) |=> !int_summary[i]);
    end

    dma_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .summary_o (int_summary),
        .irq_o     (irq)
    );

    dma_csr_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
        .csr_all   (csr_all),
        .req_level (req_level),
        .rd_ch     (rd_ch),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sim_dma_stat_irq.sv
module sim_dma_stat_irq;

    localparam int N          = 8;
    localparam int CW         = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [CW-1:0] wr_ch;
    logic [31:0]   wr_data;
    logic [CW-1:0] rd_ch;
    logic [31:0]   rd_data;
    logic [N-1:0]  evt_buserr, evt_start, evt_end, evt_stop, req_level;
    logic [N-1:0]  run_o, stop_o, int_summary;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0]  m_csr [N];
    logic [N-1:0] m_rq;
    logic [N-1:0] m_sum;
    logic         m_irq;
    logic [N-1:0] cur_rq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_stat_irq #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_data(rd_data), .evt_buserr(evt_buserr),
        .evt_start(evt_start), .evt_end(evt_end), .evt_stop(evt_stop),
        .req_level(req_level), .run_o(run_o), .stop_o(stop_o),
        .int_summary(int_summary), .irq(irq)
    );

    // Expected effect of a software write (R2 R3 R4 R5)
    function automatic logic [31:0] m_sw(logic [31:0] s, logic [31:0] d);
        logic [31:0] r;
        r = s & 32'h0000_061F;
        if (d[0]) r[0] = 1'b0;
        if (d[1]) r[1] = 1'b0;
        if (d[2]) r[2] = 1'b0;
        if (d[9]) r[9] = 1'b0;
        r = r | (d & 32'hFC80_0000);
        if (d[31]) r[3] = 1'b0;
        else if (!d[22]) r[3] = 1'b1;
        if (d[24]) r[10] = 1'b0;
        if (d[25]) r[10] = 1'b1;
        return r;
    endfunction

    // Expected pending rule (R8)
    function automatic logic m_pend(logic [31:0] s);
        return s[1] | s[2] | (s[3] & s[29]) | (s[9] & s[28]) | (s[4] & s[23]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(int rch);
        logic [31:0] er;
        logic [N-1:0] erun, estop;
        for (int i = 0; i < N; i++) begin
            erun[i]  = m_csr[i][31];
            estop[i] = m_csr[i][3];
        end
        er = m_csr[rch];
        er[8] = cur_rq[rch];
        check("R9 run_o", 32'(run_o), 32'(erun));
        check("R9 stop_o", 32'(stop_o), 32'(estop));
        check("R8 int_summary", 32'(int_summary), 32'(m_sum));
        check("R8 irq", 32'(irq), 32'(m_irq));
        check("R2 R3 R4 R5 R6 R7 readback", rd_data, er);
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge
    task automatic cycle(logic we, int ch, logic [31:0] d, logic [N-1:0] eb,
                         logic [N-1:0] es, logic [N-1:0] ee, logic [N-1:0] est,
                         logic [N-1:0] rq, int rch);
        logic [31:0] nv;
        logic [N-1:0] p;
        wr_en = we; wr_ch = CW'(ch); wr_data = d;
        evt_buserr = eb; evt_start = es; evt_end = ee; evt_stop = est;
        req_level = rq; cur_rq = rq; rd_ch = CW'(rch);
        @(posedge clk);
        for (int i = 0; i < N; i++) p[i] = m_pend(m_csr[i]);
        m_sum = p;
        m_irq = |p;
        for (int i = 0; i < N; i++) begin
            nv = m_csr[i];
            if (we && ch == i) nv = m_sw(nv, d);
            if (eb[i]) nv[0] = 1'b1;
            if (es[i]) nv[1] = 1'b1;
            if (ee[i]) nv[2] = 1'b1;
            if (est[i]) nv[3] = 1'b1;
            if (rq[i] && !m_rq[i]) nv[4] = 1'b1;
            if (!rq[i] && m_rq[i]) begin nv[4] = 1'b0; nv[9] = 1'b1; end
            m_csr[i] = nv;
        end
        m_rq = rq;
        @(negedge clk);
        wr_en = 1'b0; evt_buserr = '0; evt_start = '0; evt_end = '0; evt_stop = '0;
        check_all(rch);
    endtask

    task automatic wr(int ch, logic [31:0] d);
        cycle(1'b1, ch, d, '0, '0, '0, '0, cur_rq, ch);
    endtask

    task automatic idle(int rch);
        cycle(1'b0, 0, 32'h0, '0, '0, '0, '0, cur_rq, rch);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [N-1:0] z;
        z = '0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
        evt_buserr = '0; evt_start = '0; evt_end = '0; evt_stop = '0;
        req_level = '0; cur_rq = '0;
        for (int i = 0; i < N; i++) m_csr[i] = 32'h8;
        m_rq = '0; m_sum = '0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N; i++) begin
            rd_ch = CW'(i);
            #1 check("R1 reset status", rd_data, 32'h0000_0008);
        end
        check("R1 reset run_o", 32'(run_o), 32'h0);
        check("R1 reset stop_o", 32'(stop_o), 32'(8'hFF));
        check("R1 reset irq", 32'(irq), 32'h0);
        check("R1 reset summary", 32'(int_summary), 32'h0);
        @(negedge clk);

        // R3 control load, mask-run not stored
        wr(2, 32'hFC40_0000);
        check("R3 load ctrl", rd_data, 32'hFC00_0000);
        wr(2, 32'h0080_0000);
        check("R3 R5 rasie load stop set", rd_data, 32'h0080_0008);

        // R5 mask-run keeps stop
        wr(4, 32'h8000_0000);
        check("R5 run clears stop", rd_data, 32'h8000_0000);
        wr(4, 32'h0040_0000);
        check("R5 maskrun keeps stop clear", rd_data, 32'h0);
        check("R9 run_o ch4", 32'(run_o[4]), 32'h0);
        check("R9 stop_o ch4", 32'(stop_o[4]), 32'h0);

        // R4 compare set/clear
        wr(4, 32'h0240_0000);
        check("R4 cmp set", rd_data, 32'h0000_0400);
        wr(4, 32'h0340_0000);
        check("R4 cmp both set wins", rd_data, 32'h0000_0400);
        wr(4, 32'h0140_0000);
        check("R4 cmp clear", rd_data, 32'h0);

        // R6 hardware set beats same-cycle clear; R2 zero leaves flag
        cycle(1'b1, 1, 32'h0040_0004, z, z, 8'h02, z, cur_rq, 1);
        check("R6 end wins over clear", rd_data, 32'h0000_000C);
        wr(1, 32'h0040_0004);
        check("R2 clear end", rd_data, 32'h0000_0008);
        cycle(1'b0, 0, 32'h0, z, 8'h02, z, z, cur_rq, 1);
        wr(1, 32'h0040_0000);
        check("R2 zero keeps start", rd_data, 32'h0000_000A);
        wr(1, 32'h0040_0002);
        check("R2 clear start", rd_data, 32'h0000_0008);

        // R7 request edges and live bit 8
        cycle(1'b0, 0, 32'h0, z, z, z, z, 8'h08, 3);
        check("R7 rise sets ras", rd_data, 32'h0000_0118);
        wr(3, 32'h0040_0410);
        check("R2 bits 4 and 10 untouched", rd_data, 32'h0000_0118);
        cycle(1'b0, 0, 32'h0, z, z, z, z, 8'h00, 3);
        check("R7 fall sets eor", rd_data, 32'h0000_0208);
        wr(3, 32'h0040_0200);
        check("R2 clear eor", rd_data, 32'h0000_0008);

        // R8 bus error alone never interrupts; gated stop does
        cycle(1'b0, 0, 32'h0, 8'h20, z, z, z, cur_rq, 5);
        idle(5);
        check("R8 buserr no irq", 32'(irq), 32'h0);
        wr(5, 32'h2040_0000);
        check("R8 summary lags status", 32'(int_summary[5]), 32'h0);
        idle(5);
        check("R8 gated stop summary", 32'(int_summary[5]), 32'h1);
        check("R8 gated stop irq", 32'(irq), 32'h1);
        wr(5, 32'h8040_0001);
        idle(5);
        check("R8 irq drops", 32'(irq), 32'h0);
        cycle(1'b0, 0, 32'h0, z, 8'h40, z, z, cur_rq, 6);
        idle(6);
        check("R8 start always irq", 32'(irq), 32'h1);
        wr(6, 32'h0040_0002);
        idle(6);
        check("R8 start cleared", 32'(irq), 32'h0);

        // Random phase
        for (int k = 0; k < 5000; k++) begin
            logic we;
            logic [31:0] d;
            logic [N-1:0] eb, es, ee, est, rq;
            we = ($urandom % 3) == 0;
            d  = $urandom;
            if (($urandom % 2) == 0) d[22] = 1'b1;
            eb = '0; es = '0; ee = '0; est = '0;
            for (int i = 0; i < N; i++) begin
                eb[i]  = ($urandom % 12) == 0;
                es[i]  = ($urandom % 12) == 0;
                ee[i]  = ($urandom % 12) == 0;
                est[i] = ($urandom % 12) == 0;
            end
            rq = cur_rq;
            for (int i = 0; i < N; i++)
                if (($urandom % 8) == 0) rq[i] = ~rq[i];
            cycle(we, int'($urandom % N), d, eb, es, ee, est, rq, int'($urandom % N));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule